// File: doc/BRIEF.md
# Serial Audio Link Frame Generator (Controller Side)

This block sits at the controller end of a point-to-point serial audio link. It runs from a system clock at twice the link bit rate and derives every link timing signal from it. It produces the bit clock, the frame marker and the active-low link reset. It shifts a caller-supplied outbound bit stream onto the outbound data line at one bit per bit-clock edge. It also captures the inbound data line on rising bit-clock edges and labels each captured bit with its position in the frame.

A frame is 1000 system clocks (500 bit clocks). With a 48 MHz system clock this gives a 24 MHz bit clock and a 48 kHz frame rate. The bit source is told one system clock in advance which bit index is needed, and it answers on `tx_data` within that cycle. The link is held in reset while `hold_req` is high. When `hold_req` drops, the block waits a programmable number of bit clocks and then starts framing.

The sequencer has three states. `ST_HOLD` keeps the link in reset. `ST_WAIT` counts down the start delay. `ST_RUN` generates frames. The transitions are: `ST_HOLD`→`ST_WAIT` when `hold_req` is sampled low; `ST_WAIT`→`ST_RUN` on the rising bit-clock edge where the delay count is zero; `ST_WAIT`→`ST_HOLD` and `ST_RUN`→`ST_HOLD` when `hold_req` is sampled high. System reset forces `ST_HOLD`.

Top module: `alink_framer`

## Requirements
- R1: `bclk` is low in system reset and toggles on every system clock edge after it, so the first edge after reset is a rising bit-clock edge.
- R2: A frame lasts 1000 system clocks (frame ticks 0 to 999). Tick 0 begins on a rising `bclk` edge. `sync` goes high at the edge that begins tick 0 and stays high for exactly 16 system clocks (8 bit clocks), unless the link is put in reset first.
- R3: During tick t of a frame, `sdo` carries outbound bit 999−t. Its value changes only on falling system clock edges, midway between bit-clock edges. The value for tick t appears at the falling edge inside tick t and holds until the falling edge inside tick t+1.
- R4: While `link_rst_n` is low, `bclk` keeps toggling and both `sync` and `sdo` stay low.
- R5: `link_rst_n` is low after system reset, and it goes low at any edge where `hold_req` is sampled high. That includes the middle of a frame, which ends the frame at once. It goes high at the first edge where `hold_req` is sampled low. The first frame then begins on the (D+1)-th rising `bclk` edge after that edge, where D is `start_delay` as sampled at that edge.
- R6: At each rising `bclk` edge that begins or continues a frame, `sdi` is captured. For the cycle that follows, `rx_valid` is high, `rx_bit` holds the captured value and `rx_idx` is 499−k, where k counts rising edges from tick 0 (k = tick/2). `rx_valid` is low at all other times.
- R7: `tx_req` is high during the cycle before each edge that begins a frame tick t, and `tx_idx` is 999−t in that cycle. `tx_data` is sampled at that edge. `tx_req` is low when the next edge begins no frame tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hold_req | input | 1 | High keeps or puts the link in reset |
| start_delay | input | 8 | Bit clocks to wait (plus one) before the first frame |
| tx_data | input | 1 | Outbound bit answering the current request |
| sdi | input | 1 | Inbound serial data line |
| bclk | output | 1 | Generated bit clock |
| sync | output | 1 | Frame marker, 8 bit clocks at frame start |
| sdo | output | 1 | Outbound serial data line |
| link_rst_n | output | 1 | Active-low reset to attached devices |
| tx_req | output | 1 | Request for the bit needed at the next edge |
| tx_idx | output | 10 | Index of the requested bit |
| rx_valid | output | 1 | One-cycle strobe for a captured inbound bit |
| rx_bit | output | 1 | Captured inbound bit |
| rx_idx | output | 9 | Frame index of the captured inbound bit |

## Verification
The hardest case to reach from the ports is a link reset that lands at an arbitrary point inside a frame. If it lands within the 16-cycle sync window, the sync is cut short. The restart that follows must then line up on the correct rising edge for the chosen delay, which can be zero. To reach these cases, the stimulus runs segments of random length (some over a full frame, so the tick wraps) and then pulses `hold_req` for a random 1 to 6 cycles. It also picks a new random start delay and a new random data pattern while the link is held. A cycle-level bench model predicts every output. For each restart, the spacing between the rise of `link_rst_n` and the rise of `sync` is also measured directly.

// File: rtl/alink_pkg.sv
package alink_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } alink_state_e;

endpackage

// File: rtl/alink_bitclk.sv
module alink_bitclk (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic bit_rise
);

    logic bclk_q;
    logic past_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q    <= 1'b0;
            past_ok_q <= 1'b0;
        end else begin
            bclk_q    <= ~bclk_q;
            past_ok_q <= 1'b1;
        end
    end

    assign bclk     = bclk_q;
    // the coming edge raises the bit clock when it is currently low
    assign bit_rise = ~bclk_q;

    // R1: bit clock alternates on every system clock edge
    p_bclk_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (bclk_q != $past(bclk_q)));

endmodule

// File: rtl/alink_seq.sv
module alink_seq
    import alink_pkg::*;
#(
    parameter int TICKS  = 1000,
    parameter int DLY_W  = 8,
    localparam int TICK_W = $clog2(TICKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_req,
    input  logic [DLY_W-1:0]  start_delay,
    input  logic              bit_rise,
    output alink_state_e      state,
    output alink_state_e      nstate,
    output logic [TICK_W-1:0] ntick
);

    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS - 1);

    alink_state_e      state_q;
    logic [TICK_W-1:0] tick_q;
    logic [DLY_W-1:0]  dly_q;
    logic [DLY_W-1:0]  ndly;

    // next-state process
    always_comb begin
        nstate = state_q;
        ntick  = tick_q;
        ndly   = dly_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!hold_req) begin
                    nstate = ST_WAIT;
                    ndly   = start_delay;
                end
            end
            ST_WAIT: begin
                if (hold_req) begin
                    nstate = ST_HOLD;
                end else if (bit_rise) begin
                    if (dly_q == '0) begin
                        nstate = ST_RUN;
                        ntick  = '0;
                    end else begin
                        ndly = dly_q - 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (hold_req) begin
                    nstate = ST_HOLD;
                end else begin
                    ntick = (tick_q == TICK_LAST) ? '0 : tick_q + 1'b1;
                end
            end
            default: nstate = ST_HOLD;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            tick_q  <= '0;
            dly_q   <= '0;
        end else begin
            state_q <= nstate;
            tick_q  <= ntick;
            dly_q   <= ndly;
        end
    end

    assign state = state_q;

    // R2: even ticks fall in the high half of the bit clock
    p_tick_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (tick_q[0] == bit_rise));

    // R5: the link only leaves reset through the delay state
    p_hold_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (state_q != ST_RUN));

endmodule

// File: rtl/alink_tx.sv
module alink_tx
    import alink_pkg::*;
#(
    parameter int TICKS     = 1000,
    parameter int SYNC_BITS = 8,
    localparam int TICK_W   = $clog2(TICKS),
    localparam int SYNC_T   = 2 * SYNC_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  alink_state_e      state,
    input  alink_state_e      nstate,
    input  logic [TICK_W-1:0] ntick,
    input  logic              tx_data,
    output logic              sync,
    output logic              sdo,
    output logic              tx_req,
    output logic [TICK_W-1:0] tx_idx
);

    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS - 1);
    localparam logic [TICK_W-1:0] SYNC_END  = TICK_W'(SYNC_T);

    logic              sync_q;
    logic              stage_q;
    logic              sdo_q;
    logic              run_next;
    logic [TICK_W-1:0] sync_cnt_q;

    assign run_next = (nstate == ST_RUN);

    // request for the bit captured at the coming edge
    always_comb begin
        tx_req = run_next;
        tx_idx = run_next ? (TICK_LAST - ntick) : '0;
    end

    // output process, rising edge: marker and staged data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 1'b0;
            stage_q <= 1'b0;
        end else begin
            sync_q  <= run_next && (ntick < SYNC_END);
            stage_q <= run_next ? tx_data : 1'b0;
        end
    end

    // falling edge: launch data midway between bit-clock edges
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
        end else begin
            sdo_q <= stage_q;
        end
    end

    // width of the marker pulse, for checking only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_cnt_q <= '0;
        end else if (sync_q) begin
            sync_cnt_q <= sync_cnt_q + 1'b1;
        end else begin
            sync_cnt_q <= '0;
        end
    end

    assign sync = sync_q;
    assign sdo  = sdo_q;

    // R2: an uninterrupted marker lasts 2*SYNC_BITS system clocks
    p_sync_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync_q) && (state == ST_RUN)) |-> (sync_cnt_q == SYNC_END));

    // R4: nothing is driven while the link is held in reset
    p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (!sync_q && !stage_q));

    // R7: requests only name indices inside a frame
    p_req_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (tx_idx <= TICK_LAST));

endmodule

// File: rtl/alink_rx.sv
module alink_rx
    import alink_pkg::*;
#(
    parameter int TICKS   = 1000,
    localparam int TICK_W = $clog2(TICKS),
    localparam int RX_W   = $clog2(TICKS / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  alink_state_e      nstate,
    input  logic [TICK_W-1:0] ntick,
    input  logic              bit_rise,
    input  logic              sdi,
    output logic              rx_valid,
    output logic              rx_bit,
    output logic [RX_W-1:0]   rx_idx
);

    localparam logic [RX_W-1:0] RX_LAST = RX_W'(TICKS / 2 - 1);

    logic            valid_q;
    logic            bit_q;
    logic [RX_W-1:0] idx_q;
    logic            take;

    assign take = (nstate == ST_RUN) && bit_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            bit_q   <= 1'b0;
            idx_q   <= '0;
        end else begin
            valid_q <= take;
            if (take) begin
                bit_q <= sdi;
                idx_q <= RX_LAST - RX_W'(ntick >> 1);
            end
        end
    end

    assign rx_valid = valid_q;
    assign rx_bit   = bit_q;
    assign rx_idx   = idx_q;

    // R6: a capture strobe only follows a rising bit-clock edge
    p_rx_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> !bit_rise);

    // R6: strobes never come on two consecutive cycles
    p_rx_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

endmodule

// File: rtl/alink_framer.sv
module alink_framer
    import alink_pkg::*;
#(
    parameter int TICKS     = 1000,
    parameter int SYNC_BITS = 8,
    parameter int DLY_W     = 8,
    localparam int TICK_W   = $clog2(TICKS),
    localparam int RX_W     = $clog2(TICKS / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_req,
    input  logic [DLY_W-1:0]  start_delay,
    input  logic              tx_data,
    input  logic              sdi,
    output logic              bclk,
    output logic              sync,
    output logic              sdo,
    output logic              link_rst_n,
    output logic              tx_req,
    output logic [TICK_W-1:0] tx_idx,
    output logic              rx_valid,
    output logic              rx_bit,
    output logic [RX_W-1:0]   rx_idx
);

    logic              bit_rise;
    alink_state_e      state;
    alink_state_e      nstate;
    logic [TICK_W-1:0] ntick;

    alink_bitclk u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .bit_rise (bit_rise)
    );

    alink_seq #(
        .TICKS (TICKS),
        .DLY_W (DLY_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_req    (hold_req),
        .start_delay (start_delay),
        .bit_rise    (bit_rise),
        .state       (state),
        .nstate      (nstate),
        .ntick       (ntick)
    );

    alink_tx #(
        .TICKS     (TICKS),
        .SYNC_BITS (SYNC_BITS)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .nstate  (nstate),
        .ntick   (ntick),
        .tx_data (tx_data),
        .sync    (sync),
        .sdo     (sdo),
        .tx_req  (tx_req),
        .tx_idx  (tx_idx)
    );

    alink_rx #(
        .TICKS (TICKS)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .nstate   (nstate),
        .ntick    (ntick),
        .bit_rise (bit_rise),
        .sdi      (sdi),
        .rx_valid (rx_valid),
        .rx_bit   (rx_bit),
        .rx_idx   (rx_idx)
    );

    assign link_rst_n = (state != ST_HOLD);

    // R4: the link reset output and the marker are never active together
    p_no_sync_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !link_rst_n |-> !sync);

endmodule

// File: tb/test_alink_framer.sv
module test_alink_framer;

    localparam int CLK_PERIOD = 10;
    localparam int TICKS      = 1000;
    localparam int SYNC_T     = 16;

    logic       clk;
    logic       rst_n;
    logic       hold_req;
    logic [7:0] start_delay;
    logic       tx_data;
    logic       sdi;
    logic       bclk, sync, sdo, link_rst_n, tx_req, rx_valid, rx_bit;
    logic [9:0] tx_idx;
    logic [8:0] rx_idx;
    logic [31:0] pat_seed;

    int checks = 0;
    int bad    = 0;

    // bench model state
    int m_state;   // 0 hold, 1 wait, 2 run
    int m_tick, m_dly, m_bclk, m_sdo, m_rxv, m_rxb, m_rxi;
    int cyc = 0;
    int rel_cyc, rel_bclk, rel_d;
    bit rel_armed;
    logic prev_rst, prev_sync;

    alink_framer i_alink_framer (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .start_delay(start_delay),
        .tx_data(tx_data), .sdi(sdi), .bclk(bclk), .sync(sync), .sdo(sdo),
        .link_rst_n(link_rst_n), .tx_req(tx_req), .tx_idx(tx_idx),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_idx(rx_idx)
    );

    function automatic logic pat_bit(input int idx, input logic [31:0] seed);
        logic [31:0] h;
        h = (32'(idx) + 32'd1) * 32'h9E3779B1 ^ seed;
        return h[13] ^ h[7] ^ h[29];
    endfunction

    assign tx_data = pat_bit(int'(tx_idx), pat_seed);

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // next-state prediction from the requirements (R5, R2)
    task automatic predict(input int hold, input int d, output int ns, output int nt, output int nd);
        ns = m_state; nt = m_tick; nd = m_dly;
        case (m_state)
            0: if (hold == 0) begin ns = 1; nd = d; end
            1: if (hold != 0) ns = 0;
               else if (m_bclk == 0) begin
                   if (m_dly == 0) begin ns = 2; nt = 0; end
                   else nd = m_dly - 1;
               end
            default: if (hold != 0) ns = 0; else nt = (m_tick + 1) % TICKS;
        endcase
    endtask

    task automatic cycle(input logic hold_next, input logic sdi_next);
        int ns, nt, nd, rise;
        @(posedge clk);
        cyc++;
        rise = (m_bclk == 0);
        predict(int'(hold_req), int'(start_delay), ns, nt, nd);
        m_rxv = (ns == 2) && rise;
        if (m_rxv) begin m_rxb = int'(sdi); m_rxi = 499 - nt / 2; end
        m_state = ns; m_tick = nt; m_dly = nd;
        m_bclk = 1 - m_bclk;
        #2;
        // R3: outbound line still holds the previous bit before the falling edge
        chk("R3 sdo held to mid-point", int'(sdo), m_sdo);
        m_sdo = (m_state == 2) ? int'(pat_bit(TICKS - 1 - m_tick, pat_seed)) : 0;
        hold_req = hold_next;
        sdi      = sdi_next;
        #5;
        chk("R1 bclk", int'(bclk), m_bclk);
        chk("R5 link_rst_n", int'(link_rst_n), (m_state != 0) ? 1 : 0);
        chk("R2 sync", int'(sync), (m_state == 2 && m_tick < SYNC_T) ? 1 : 0);
        chk("R3 sdo bit", int'(sdo), m_sdo);
        if (m_state == 0) begin
            chk("R4 sync quiet in reset", int'(sync), 0);
            chk("R4 sdo quiet in reset", int'(sdo), 0);
        end
        chk("R6 rx_valid", int'(rx_valid), m_rxv);
        if (m_rxv != 0) begin
            chk("R6 rx_bit", int'(rx_bit), m_rxb);
            chk("R6 rx_idx", int'(rx_idx), m_rxi);
        end
        predict(int'(hold_req), int'(start_delay), ns, nt, nd);
        chk("R7 tx_req", int'(tx_req), (ns == 2) ? 1 : 0);
        if (ns == 2) chk("R7 tx_idx", int'(tx_idx), TICKS - 1 - nt);
        // R5: directly measured spacing from reset release to first marker
        if (!prev_rst && link_rst_n) begin
            rel_armed = 1'b1; rel_cyc = cyc; rel_bclk = int'(bclk); rel_d = int'(start_delay);
        end
        if (!link_rst_n) rel_armed = 1'b0;
        if (rel_armed && !prev_sync && sync) begin
            chk("R5 start delay spacing", cyc - rel_cyc,
                (rel_bclk != 0) ? 2 * rel_d + 2 : 2 * rel_d + 1);
            rel_armed = 1'b0;
        end
        prev_rst  = link_rst_n;
        prev_sync = sync;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog cycle=%0d actual=hung expected=done", cyc);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1729));
        rst_n = 1'b0; hold_req = 1'b1; start_delay = 8'd3; sdi = 1'b0;
        pat_seed = 32'h1234_5678;
        m_state = 0; m_tick = 0; m_dly = 0; m_bclk = 0; m_sdo = 0;
        m_rxv = 0; m_rxb = 0; m_rxi = 0;
        rel_armed = 1'b0; rel_cyc = 0; rel_bclk = 0; rel_d = 0;
        prev_rst = 1'b0; prev_sync = 1'b0;
        repeat (3) @(posedge clk);
        #7;
        chk("R1 bclk low in reset", int'(bclk), 0);
        chk("R5 link_rst_n low in reset", int'(link_rst_n), 0);
        chk("R4 sync low in reset", int'(sync), 0);
        chk("R4 sdo low in reset", int'(sdo), 0);
        chk("R6 rx_valid low in reset", int'(rx_valid), 0);
        chk("R7 tx_req low in reset", int'(tx_req), 0);
        @(negedge clk);
        #2 rst_n = 1'b1;
        // directed: held link, then delay 3 over two whole frames
        repeat (6) cycle(1'b1, 1'b0);
        for (int i = 0; i < 2200; i++) cycle(1'b0, 1'($urandom));
        // directed: delay zero, single-cycle hold pulse, restart
        start_delay = 8'd0;
        cycle(1'b1, 1'b0);
        for (int i = 0; i < 1100; i++) cycle(1'b0, 1'($urandom));
        // directed: hold lands inside the marker window
        cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b0);
        for (int i = 0; i < 7; i++) cycle(1'b0, 1'($urandom));
        cycle(1'b1, 1'b0);
        // random segments with random delays, patterns and hold lengths
        for (int s = 0; s < 35; s++) begin
            int len, hl;
            start_delay = 8'($urandom_range(0, 15));
            pat_seed    = $urandom;
            hl  = $urandom_range(1, 6);
            for (int h = 0; h < hl; h++) cycle(1'b1, 1'($urandom));
            len = (s % 4 == 0) ? $urandom_range(1000, 2600) : $urandom_range(5, 900);
            for (int i = 0; i < len; i++) cycle(1'b0, 1'($urandom));
        end
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule